// File: doc/BRIEF.md
# Keyboard Controller Command Processor

This block is the host-facing half of a PC-style keyboard controller. The host sees two byte-wide ports. One is a data port and the other is a command/status port. A byte written to the command port is decoded as a controller command. A byte written to the data port is either consumed by a command that is waiting for it, or forwarded to the keyboard device. The status byte is always present on a dedicated output, so a host read of the command/status port simply samples it.

The block holds three pieces of state: the controller mode byte, the controller output-port byte and the self-test flag. Commands can:

- read any of these back as reply bytes;
- flip single mode bits;
- drive the A20 gate line, which always mirrors output-port bit 1;
- request a system reset.

Two-phase commands first record a pending write target. The next data-port byte then goes to the mode register, the output port, the keyboard reply channel, the auxiliary reply channel or the mouse. Reply bytes leave on a push interface tagged keyboard or auxiliary. Bytes bound for the keyboard or mouse leave on a separate push interface. The serial line protocol and the devices themselves are outside this block.

Top module: `kbd_ctl_cmd`

## Requirements
- R1: After reset the mode byte is 0x03, the output-port byte is 0x03 (so `a20_gate` is 1), the status byte is 0x18, `xlate_en` is 0, and no reply, device or reset pulse is active.
- R2: The status byte has bit 2 = self-test passed, bits 3 and 4 always 1, and bits 0, 1 and 5 to 7 always 0. In particular, the input-buffer-full bit 1 always reads 0.
- R3: Command 0x20 replies the current mode byte and command 0xD0 replies the current output-port byte. Both replies go on the keyboard channel (`rep_aux` = 0).
- R4: Command 0xAA sets status bit 2 and replies 0x55. Commands 0xA9, 0xAB and 0xC0 each reply 0x00 on the keyboard channel.
- R5: Commands 0xA7 and 0xA8 set and clear mode bit 5. Commands 0xAD and 0xAE set and clear mode bit 4. Neither command produces a reply.
- R6: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 record a pending target. The next data write then goes as follows:
  - 0x60: the byte is stored as the mode byte.
  - 0xD1: the byte is stored as the output-port byte.
  - 0xD2: the byte is replied on the keyboard channel.
  - 0xD3: the byte is replied on the auxiliary channel (`rep_aux` = 1).
  - 0xD4: the byte is forwarded to the mouse (`dev_to_mouse` = 1).

  After that data write the target clears. A later target command replaces an earlier one.
- R7: A data write with no pending target is forwarded to the keyboard (`dev_valid` = 1, `dev_to_mouse` = 0).
- R8: A command with upper nibble 0xF is a pulse command. If its bit 0 is 0 it raises `sys_rst_req`; if its bit 0 is 1 it has no effect.
- R9: Command 0xDF sets output-port bit 1 and command 0xDD clears it. `a20_gate` follows that bit.
- R10: A data write to the output port stores the whole byte and drives `a20_gate` from its bit 1. If its bit 0 is 0, it raises `sys_rst_req`.
- R11: A data write to the mode byte sets `xlate_en` to bit 6 of the written byte.
- R12: A command byte not listed in R3 to R9 changes nothing: no output, no register and no pending target.
- R13: Every result of a write appears in the cycle after the clock edge that samples it. `rep_valid`, `dev_valid` and `sys_rst_req` each last one cycle per write, and at most one of `rep_valid` and `dev_valid` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one byte per cycle |
| wr_cmd | input | 1 | 1 = command/status port, 0 = data port |
| wr_data | input | 8 | Host write byte |
| status | output | 8 | Status byte (host read of command/status port) |
| rep_valid | output | 1 | Reply byte push |
| rep_aux | output | 1 | Reply tag: 1 = auxiliary channel, 0 = keyboard channel |
| rep_data | output | 8 | Reply byte |
| dev_valid | output | 1 | Device-bound byte push |
| dev_to_mouse | output | 1 | 1 = mouse, 0 = keyboard |
| dev_data | output | 8 | Device-bound byte |
| a20_gate | output | 1 | A20 gate line (output-port bit 1) |
| sys_rst_req | output | 1 | Single-cycle system reset request |
| xlate_en | output | 1 | Scan-code translation enable (mode bit 6) |

## Verification
The following results are registered once and are due in the cycle that follows the clock edge sampling the write: replies, device bytes, reset pulses, `a20_gate`, `xlate_en` and status changes. The bench drives each write on a falling edge and holds it across exactly one rising edge. It then checks every output at the next falling edge, which is where that single registered result is visible, and drops the strobe at the same moment. A two-phase command is therefore checked as two such writes, and the pending target is observed only through where the following data byte lands.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int unsigned BYTE_W = 8;

  // mode byte bit positions
  localparam int unsigned MODE_KBD_OFF_BIT   = 4;
  localparam int unsigned MODE_MOUSE_OFF_BIT = 5;
  localparam int unsigned MODE_XLATE_BIT     = 6;

  // output-port bit positions
  localparam int unsigned OPORT_RUN_BIT = 0;
  localparam int unsigned OPORT_A20_BIT = 1;

  // status byte bit positions
  localparam int unsigned STAT_SELFTEST_BIT = 2;
  localparam int unsigned STAT_LASTCMD_BIT  = 3;
  localparam int unsigned STAT_UNLOCK_BIT   = 4;

  typedef enum logic [2:0] {
    TGT_NONE   = 3'd0,
    TGT_MODE   = 3'd1,
    TGT_OPORT  = 3'd2,
    TGT_KREPLY = 3'd3,
    TGT_AREPLY = 3'd4,
    TGT_MOUSE  = 3'd5
  } tgt_e;

  typedef struct packed {
    logic              rd_mode;
    logic              rd_oport;
    logic              rd_const;
    logic [BYTE_W-1:0] const_val;
    logic              set_selftest;
    logic              set_tgt;
    tgt_e              tgt;
    logic              mouse_off;
    logic              mouse_on;
    logic              kbd_off;
    logic              kbd_on;
    logic              a20_on;
    logic              a20_off;
    logic              pulse_rst;
  } cmd_dec_t;
endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
  import kbc_pkg::*;
(
  input  logic [BYTE_W-1:0] cmd,
  output cmd_dec_t          dec
);
  always_comb begin
    dec = '0;
    dec.tgt = TGT_NONE;
    if (cmd[7:4] == 4'hF) begin
      // pulse family: bit 0 low pulses reset, high does nothing
      dec.pulse_rst = ~cmd[0];
    end else begin
      unique case (cmd)
        8'h20: dec.rd_mode  = 1'b1;
        8'hD0: dec.rd_oport = 1'b1;
        8'hAA: begin
          dec.set_selftest = 1'b1;
          dec.rd_const     = 1'b1;
          dec.const_val    = 8'h55;
        end
        8'hA9, 8'hAB, 8'hC0: begin
          dec.rd_const  = 1'b1;
          dec.const_val = 8'h00;
        end
        8'h60: begin dec.set_tgt = 1'b1; dec.tgt = TGT_MODE;   end
        8'hD1: begin dec.set_tgt = 1'b1; dec.tgt = TGT_OPORT;  end
        8'hD2: begin dec.set_tgt = 1'b1; dec.tgt = TGT_KREPLY; end
        8'hD3: begin dec.set_tgt = 1'b1; dec.tgt = TGT_AREPLY; end
        8'hD4: begin dec.set_tgt = 1'b1; dec.tgt = TGT_MOUSE;  end
        8'hA7: dec.mouse_off = 1'b1;
        8'hA8: dec.mouse_on  = 1'b1;
        8'hAD: dec.kbd_off   = 1'b1;
        8'hAE: dec.kbd_on    = 1'b1;
        8'hDF: dec.a20_on    = 1'b1;
        8'hDD: dec.a20_off   = 1'b1;
        default: ; // unknown: no action
      endcase
    end
  end
endmodule

// File: rtl/kbc_state.sv
module kbc_state
  import kbc_pkg::*;
#(
  parameter logic [BYTE_W-1:0] RESET_MODE  = 8'h03,
  parameter logic [BYTE_W-1:0] RESET_OPORT = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_cmd,
  input  logic [BYTE_W-1:0] wr_data,
  input  cmd_dec_t          dec,
  output logic [BYTE_W-1:0] mode_q,
  output logic [BYTE_W-1:0] oport_q,
  output logic              selftest_q,
  output tgt_e              tgt_q
);
  logic [BYTE_W-1:0] mode_d, oport_d;
  logic              selftest_d;
  tgt_e              tgt_d;
  logic              cmd_we, data_we;

  assign cmd_we  = wr_en &  wr_cmd;
  assign data_we = wr_en & ~wr_cmd;

  always_comb begin
    mode_d     = mode_q;
    oport_d    = oport_q;
    selftest_d = selftest_q;
    tgt_d      = tgt_q;
    if (cmd_we) begin
      if (dec.mouse_off)    mode_d[MODE_MOUSE_OFF_BIT] = 1'b1;
      if (dec.mouse_on)     mode_d[MODE_MOUSE_OFF_BIT] = 1'b0;
      if (dec.kbd_off)      mode_d[MODE_KBD_OFF_BIT]   = 1'b1;
      if (dec.kbd_on)       mode_d[MODE_KBD_OFF_BIT]   = 1'b0;
      if (dec.a20_on)       oport_d[OPORT_A20_BIT]     = 1'b1;
      if (dec.a20_off)      oport_d[OPORT_A20_BIT]     = 1'b0;
      if (dec.set_selftest) selftest_d = 1'b1;
      if (dec.set_tgt)      tgt_d      = dec.tgt;
    end else if (data_we) begin
      tgt_d = TGT_NONE;
      if (tgt_q == TGT_MODE)  mode_d  = wr_data;
      if (tgt_q == TGT_OPORT) oport_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= RESET_MODE;
      oport_q    <= RESET_OPORT;
      selftest_q <= 1'b0;
      tgt_q      <= TGT_NONE;
    end else if (wr_en) begin
      mode_q     <= mode_d;
      oport_q    <= oport_d;
      selftest_q <= selftest_d;
      tgt_q      <= tgt_d;
    end
  end
endmodule

// File: rtl/kbc_emit.sv
module kbc_emit
  import kbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_cmd,
  input  logic [BYTE_W-1:0] wr_data,
  input  cmd_dec_t          dec,
  input  tgt_e              tgt_q,
  input  logic [BYTE_W-1:0] mode_q,
  input  logic [BYTE_W-1:0] oport_q,
  output logic              rep_valid,
  output logic              rep_aux,
  output logic [BYTE_W-1:0] rep_data,
  output logic              dev_valid,
  output logic              dev_to_mouse,
  output logic [BYTE_W-1:0] dev_data,
  output logic              sys_rst_req
);
  logic              rv_d, ra_d, dv_d, dm_d, rst_d;
  logic [BYTE_W-1:0] rd_d, dd_d;

  always_comb begin
    rv_d  = 1'b0;
    ra_d  = 1'b0;
    rd_d  = '0;
    dv_d  = 1'b0;
    dm_d  = 1'b0;
    dd_d  = '0;
    rst_d = 1'b0;
    if (wr_en && wr_cmd) begin
      rv_d  = dec.rd_mode | dec.rd_oport | dec.rd_const;
      rd_d  = dec.rd_mode ? mode_q : (dec.rd_oport ? oport_q : dec.const_val);
      rst_d = dec.pulse_rst;
    end else if (wr_en) begin
      unique case (tgt_q)
        TGT_KREPLY: begin rv_d = 1'b1; rd_d = wr_data; end
        TGT_AREPLY: begin rv_d = 1'b1; ra_d = 1'b1; rd_d = wr_data; end
        TGT_MOUSE:  begin dv_d = 1'b1; dm_d = 1'b1; dd_d = wr_data; end
        TGT_NONE:   begin dv_d = 1'b1; dd_d = wr_data; end
        TGT_OPORT:  rst_d = ~wr_data[OPORT_RUN_BIT];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep_valid    <= 1'b0;
      rep_aux      <= 1'b0;
      rep_data     <= '0;
      dev_valid    <= 1'b0;
      dev_to_mouse <= 1'b0;
      dev_data     <= '0;
      sys_rst_req  <= 1'b0;
    end else begin
      rep_valid    <= rv_d;
      dev_valid    <= dv_d;
      sys_rst_req  <= rst_d;
      if (rv_d) begin
        rep_aux  <= ra_d;
        rep_data <= rd_d;
      end
      if (dv_d) begin
        dev_to_mouse <= dm_d;
        dev_data     <= dd_d;
      end
    end
  end
endmodule

// File: rtl/kbd_ctl_cmd.sv
module kbd_ctl_cmd
  import kbc_pkg::*;
#(
  parameter logic [7:0] RESET_MODE  = 8'h03,
  parameter logic [7:0] RESET_OPORT = 8'h03
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_cmd,
  input  logic [7:0] wr_data,
  output logic [7:0] status,
  output logic       rep_valid,
  output logic       rep_aux,
  output logic [7:0] rep_data,
  output logic       dev_valid,
  output logic       dev_to_mouse,
  output logic [7:0] dev_data,
  output logic       a20_gate,
  output logic       sys_rst_req,
  output logic       xlate_en
);
  cmd_dec_t          dec;
  logic [BYTE_W-1:0] mode_q, oport_q;
  logic              selftest_q;
  tgt_e              tgt_q;

  kbc_cmd_decode u_dec (.cmd(wr_data), .dec(dec));

  kbc_state #(.RESET_MODE(RESET_MODE), .RESET_OPORT(RESET_OPORT)) u_state (
    .clk, .rst_n, .wr_en, .wr_cmd, .wr_data, .dec,
    .mode_q, .oport_q, .selftest_q, .tgt_q
  );

  kbc_emit u_emit (
    .clk, .rst_n, .wr_en, .wr_cmd, .wr_data, .dec, .tgt_q, .mode_q, .oport_q,
    .rep_valid, .rep_aux, .rep_data, .dev_valid, .dev_to_mouse, .dev_data,
    .sys_rst_req
  );

  always_comb begin
    status = '0;
    status[STAT_SELFTEST_BIT] = selftest_q;
    status[STAT_LASTCMD_BIT]  = 1'b1;
    status[STAT_UNLOCK_BIT]   = 1'b1;
  end

  assign a20_gate = oport_q[OPORT_A20_BIT];
  assign xlate_en = mode_q[MODE_XLATE_BIT];
endmodule

// File: rtl/kbc_chk.sv
module kbc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       wr_cmd,
  input logic [7:0] status,
  input logic       rep_valid,
  input logic       dev_valid,
  input logic       a20_gate,
  input logic       sys_rst_req,
  input logic       xlate_en
);
  a_r13_reply_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid |-> $past(wr_en));
  a_r7_dev_follows_data_write: assert property (@(posedge clk) disable iff (!rst_n)
    dev_valid |-> $past(wr_en && !wr_cmd));
  a_r13_single_result: assert property (@(posedge clk) disable iff (!rst_n)
    !(rep_valid && dev_valid));
  a_r2_status_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1:0] == 2'b00) && (status[4:3] == 2'b11) && (status[7:5] == 3'b000));
  a_r4_selftest_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(status[2]) |-> status[2]);
  a_r9_a20_holds_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(a20_gate));
  a_r10_reset_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> $past(wr_en));
  a_r11_xlate_only_by_data: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en && !wr_cmd) |-> $stable(xlate_en));
endmodule

bind kbd_ctl_cmd kbc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_cmd), .status(status),
  .rep_valid(rep_valid), .dev_valid(dev_valid), .a20_gate(a20_gate),
  .sys_rst_req(sys_rst_req), .xlate_en(xlate_en)
);

// File: tb/sim_kbd_ctl_cmd.sv
module sim_kbd_ctl_cmd;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, wr_cmd;
  logic [7:0] wr_data;
  logic [7:0] status, rep_data, dev_data;
  logic       rep_valid, rep_aux, dev_valid, dev_to_mouse, a20_gate, sys_rst_req, xlate_en;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk; // 125 MHz

  kbd_ctl_cmd u0 (.*);

  typedef struct packed {
    logic       c;   // 1 = command port
    logic [7:0] d;
    logic       rv;
    logic       ra;
    logic [7:0] rd;
    logic       dv;
    logic       dm;
    logic [7:0] dd;
    logic       a20;
    logic       rs;
    logic       xl;
    logic [3:0] rq;
  } vec_t;

  function automatic vec_t mk(logic c, logic [7:0] d, logic rv, logic ra, logic [7:0] rd,
                              logic dv, logic dm, logic [7:0] dd, logic a20, logic rs,
                              logic xl, logic [3:0] rq);
    mk = '{c, d, rv, ra, rd, dv, dm, dd, a20, rs, xl, rq};
  endfunction

  localparam int NV = 46;
  localparam vec_t TBL [NV] = '{
    mk(1, 8'h20, 1,0,8'h03, 0,0,8'h00, 1,0,0, 4'd3),  // R3 mode readback
    mk(1, 8'hA7, 0,0,8'h00, 0,0,8'h00, 1,0,0, 4'd5),  // R5 mouse off
    mk(1, 8'h20, 1,0,8'h23, 0,0,8'h00, 1,0,0, 4'd5),  // R5
    mk(1, 8'hAD, 0,0,8'h00, 0,0,8'h00, 1,0,0, 4'd5),  // R5 kbd off
    mk(1, 8'h20, 1,0,8'h33, 0,0,8'h00, 1,0,0, 4'd5),  // R5
    mk(1, 8'hA8, 0,0,8'h00, 0,0,8'h00, 1,0,0, 4'd5),  // R5
    mk(1, 8'hAE, 0,0,8'h00, 0,0,8'h00, 1,0,0, 4'd5),  // R5
    mk(1, 8'h20, 1,0,8'h03, 0,0,8'h00, 1,0,0, 4'd5),  // R5
    mk(1, 8'hAA, 1,0,8'h55, 0,0,8'h00, 1,0,0, 4'd4),  // R4 self test
    mk(1, 8'hA9, 1,0,8'h00, 0,0,8'h00, 1,0,0, 4'd4),  // R4
    mk(1, 8'hAB, 1,0,8'h00, 0,0,8'h00, 1,0,0, 4'd4),  // R4
    mk(1, 8'hC0, 1,0,8'h00, 0,0,8'h00, 1,0,0, 4'd4),  // R4
    mk(1, 8'hD0, 1,0,8'h03, 0,0,8'h00, 1,0,0, 4'd3),  // R3 oport readback
    mk(1, 8'hDD, 0,0,8'h00, 0,0,8'h00, 0,0,0, 4'd9),  // R9 A20 off
    mk(1, 8'hD0, 1,0,8'h01, 0,0,8'h00, 0,0,0, 4'd9),  // R9
    mk(1, 8'hDF, 0,0,8'h00, 0,0,8'h00, 1,0,0, 4'd9),  // R9 A20 on
    mk(1, 8'hD0, 1,0,8'h03, 0,0,8'h00, 1,0,0, 4'd9),  // R9
    mk(0, 8'h5A, 0,0,8'h00, 1,0,8'h5A, 1,0,0, 4'd7),  // R7 plain data
    mk(1, 8'hD4, 0,0,8'h00, 0,0,8'h00, 1,0,0, 4'd6),  // R6 to mouse
    mk(0, 8'h77, 0,0,8'h00, 1,1,8'h77, 1,0,0, 4'd6),  // R6
    mk(0, 8'h11, 0,0,8'h00, 1,0,8'h11, 1,0,0, 4'd6),  // R6 target cleared
    mk(1, 8'hD2, 0,0,8'h00, 0,0,8'h00, 1,0,0, 4'd6),  // R6 kbd reply
    mk(0, 8'hAB, 1,0,8'hAB, 0,0,8'h00, 1,0,0, 4'd6),  // R6
    mk(1, 8'hD3, 0,0,8'h00, 0,0,8'h00, 1,0,0, 4'd6),  // R6 aux reply
    mk(0, 8'hCD, 1,1,8'hCD, 0,0,8'h00, 1,0,0, 4'd6),  // R6
    mk(1, 8'hD4, 0,0,8'h00, 0,0,8'h00, 1,0,0, 4'd6),  // R6 replaced target
    mk(1, 8'hD2, 0,0,8'h00, 0,0,8'h00, 1,0,0, 4'd6),  // R6
    mk(0, 8'h3C, 1,0,8'h3C, 0,0,8'h00, 1,0,0, 4'd6),  // R6
    mk(1, 8'h60, 0,0,8'h00, 0,0,8'h00, 1,0,0, 4'd11), // R11 mode write
    mk(0, 8'h47, 0,0,8'h00, 0,0,8'h00, 1,0,1, 4'd11), // R11 xlate on
    mk(1, 8'h20, 1,0,8'h47, 0,0,8'h00, 1,0,1, 4'd11), // R11
    mk(1, 8'hD1, 0,0,8'h00, 0,0,8'h00, 1,0,1, 4'd10), // R10 oport write
    mk(0, 8'h01, 0,0,8'h00, 0,0,8'h00, 0,0,1, 4'd10), // R10 A20 off, no reset
    mk(1, 8'hD0, 1,0,8'h01, 0,0,8'h00, 0,0,1, 4'd10), // R10
    mk(1, 8'hD1, 0,0,8'h00, 0,0,8'h00, 0,0,1, 4'd10), // R10
    mk(0, 8'h02, 0,0,8'h00, 0,0,8'h00, 1,1,1, 4'd10), // R10 reset request
    mk(1, 8'hFE, 0,0,8'h00, 0,0,8'h00, 1,1,1, 4'd8),  // R8
    mk(1, 8'hF1, 0,0,8'h00, 0,0,8'h00, 1,0,1, 4'd8),  // R8 no-op
    mk(1, 8'hF0, 0,0,8'h00, 0,0,8'h00, 1,1,1, 4'd8),  // R8
    mk(1, 8'hFF, 0,0,8'h00, 0,0,8'h00, 1,0,1, 4'd8),  // R8
    mk(1, 8'hF6, 0,0,8'h00, 0,0,8'h00, 1,1,1, 4'd8),  // R8
    mk(1, 8'h12, 0,0,8'h00, 0,0,8'h00, 1,0,1, 4'd12), // R12 unknown
    mk(1, 8'hD0, 1,0,8'h02, 0,0,8'h00, 1,0,1, 4'd12), // R12 oport intact
    mk(1, 8'hD2, 0,0,8'h00, 0,0,8'h00, 1,0,1, 4'd12), // R12 target set
    mk(1, 8'hB5, 0,0,8'h00, 0,0,8'h00, 1,0,1, 4'd12), // R12 unknown keeps target
    mk(0, 8'h99, 1,0,8'h99, 0,0,8'h00, 1,0,1, 4'd12)  // R12
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic c, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_cmd = c; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] pack_out();
    pack_out = {5'b0, rep_valid, rep_valid & rep_aux, rep_valid ? rep_data : 8'h00,
                dev_valid, dev_valid & dev_to_mouse, dev_valid ? dev_data : 8'h00,
                a20_gate, sys_rst_req, xlate_en};
  endfunction

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wr_en = 1'b0; wr_cmd = 1'b0; wr_data = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, R2 status layout
    check("R1 status", {24'b0, status}, 32'h18);
    check("R1 outputs", pack_out(), {5'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0});
    check("R2 ibf clear", {31'b0, status[1]}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(TBL[i].c, TBL[i].d);
      check($sformatf("R%0d vec%0d", TBL[i].rq, i), pack_out(),
            {5'b0, TBL[i].rv, TBL[i].ra, TBL[i].rd, TBL[i].dv, TBL[i].dm, TBL[i].dd,
             TBL[i].a20, TBL[i].rs, TBL[i].xl});
      if (i == 8) check("R4 selftest status", {24'b0, status}, 32'h1C);
    end

    // R13: pulses drop one cycle later
    wr(1'b1, 8'hFE);
    @(negedge clk);
    check("R13 pulse width", {31'b0, sys_rst_req}, 32'h0);
    wr(1'b0, 8'h42);
    @(negedge clk);
    check("R13 dev width", {31'b0, dev_valid}, 32'h0);

    // R1 reset mid-run restores state
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 status after reset", {24'b0, status}, 32'h18);
    check("R1 xlate/a20 after reset", {30'b0, a20_gate, xlate_en}, 32'h2);
    wr(1'b1, 8'h20);
    check("R1 mode after reset", {23'b0, rep_valid, rep_data}, 32'h103);
    // R2: status bit 1 still clear while a target is pending
    wr(1'b1, 8'h60);
    check("R2 ibf with pending", {31'b0, status[1]}, 32'h0);
    wr(1'b0, 8'h00);
    check("R11 xlate off", {31'b0, xlate_en}, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule